// File: doc/BRIEF.md
# Dual-RAM Indirect Access Window

This block gives a host a small register window onto two local word memories: a communication RAM and a coprocessor work RAM. The host works on a 16-bit data bus with an 8-bit register address. It programs an offset, then streams words through a single data port. Each data-port access reaches the RAM chosen by a select bit in the control register, and the offset then steps to the next word on its own. Words are stored with their two bytes exchanged and are exchanged back on the way out. A host can therefore fill or dump a buffer with one offset write followed by back-to-back data-port accesses.

A 0-to-1 write of the initialisation bit in the control register starts the link sequence. The block zeroes the first sixteen words of the communication RAM and clears both status registers. It then waits for the `link_ready` input. On the first cycle that `link_ready` is seen high, it loads the ready pattern and the node information into the status registers. The host may also write the status registers directly.

Each RAM holds `2**RAM_AW` words (2 K words by default). The offset register is a full 16-bit byte address, so offsets beyond the RAM depth alias back onto it.

Top module: `dualram_window`

## Requirements
- R1: Register addresses on `bus_addr` are CTRL 0x00, OFFSET 0x04, DATA 0x08, STATUS0 0x0C and STATUS1 0x10. A host write to CTRL, OFFSET, STATUS0 or STATUS1 stores the full 16-bit value, and a later read of that register returns it.
- R2: A read request (`bus_req`=1, `bus_we`=0) is answered in the next cycle with `rd_valid`=1 and the data on `rd_data`. `rd_valid` is 0 in every other cycle. A write takes effect at the clock edge where it is presented.
- R3: A read of any other address returns 0xFFFF. A write to any other address changes no register and no RAM word.
- R4: CTRL bit 0 selects the RAM that the data port reaches: 0 selects the communication RAM and 1 selects the coprocessor RAM. A write to one RAM leaves the same word of the other RAM unchanged.
- R5: Every data-port read or write uses the word at the current OFFSET, and OFFSET then increases by 2, wrapping from 0xFFFE to 0x0000. OFFSET bit 0 is ignored for addressing. The RAM word index is OFFSET bits [RAM_AW:1].
- R6: A word is stored byte-swapped and is swapped back when read through the data port, so a data-port write followed by a data-port read of the same word returns the written value.
- R7: A CTRL write that changes bit 5 from 0 to 1 sets STATUS0 and STATUS1 to 0 and makes communication RAM words 0 to 15 read as 0. Coprocessor RAM and communication words 16 and above are left as they were. Writing CTRL with bit 5 already at 1 does none of this.
- R8: After such an edge, on the first cycle (from the cycle after the edge onwards) with `link_ready`=1, STATUS0 becomes 0xFF01 and STATUS1 becomes {`node_count`, `node_id`}. This load happens once per edge, and a host status write made in the same cycle takes precedence.
- R9: After `rst`, CTRL, OFFSET, STATUS0 and STATUS1 read 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 16 | Read data |
| link_ready | input | 1 | Connection ready; sampled after an initialisation edge |
| node_count | input | 8 | Number of nodes, loaded into STATUS1 upper byte |
| node_id | input | 8 | Local node number, loaded into STATUS1 lower byte |

## Verification
A wrong offset or a wrong bank select shows on the very next data-port read: the word that comes back belongs to another location, or it comes from a RAM not yet written. A stale zero flag shows as a word reading zero after it was rewritten. A status unit that loads too early or loads twice is exposed by a STATUS read one cycle after the relevant edge. The reference model predicts every read response cycle by cycle, so each such fault surfaces in the first read that touches the corrupted state.

// File: rtl/dualram_window_pkg.sv
package dualram_window_pkg;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_OFFS = 8'h04;
  localparam logic [7:0] A_DATA = 8'h08;
  localparam logic [7:0] A_STS0 = 8'h0C;
  localparam logic [7:0] A_STS1 = 8'h10;

  localparam int CB_SEL  = 0;
  localparam int CB_INIT = 5;

  localparam logic [15:0] STS0_READY = 16'hFF01;
  localparam logic [15:0] RD_UNMAPPED = 16'hFFFF;

  function automatic logic [15:0] swap16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/dw_word_ram.sv
module dw_word_ram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/dw_zero_mask.sv
module dw_zero_mask #(
  parameter int AW = 11,
  parameter int N  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] idx,
  output logic          hit_q
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  mask;
  logic          in_range;
  logic [IW-1:0] slot;

  assign in_range = (idx < AW'(N));
  assign slot     = idx[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '0;
      hit_q <= 1'b0;
    end else begin
      if (clr) mask <= '1;
      else if (wr && in_range) mask[slot] <= 1'b0;
      hit_q <= rd && in_range && mask[slot];
    end
  end

  // R7
  clear_sets_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (&mask));

  // R7
  write_unmasks_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && in_range && !clr) |=> !mask[$past(slot)]);
endmodule

// File: rtl/dw_status_unit.sv
module dw_status_unit
  import dualram_window_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        arm,
  input  logic        wr0,
  input  logic        wr1,
  input  logic [15:0] wdata,
  input  logic        link_ready,
  input  logic [7:0]  node_count,
  input  logic [7:0]  node_id,
  output logic [15:0] sts0,
  output logic [15:0] sts1
);
  logic armed;
  logic load;

  assign load = armed && link_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      sts0  <= '0;
      sts1  <= '0;
    end else begin
      if (arm) armed <= 1'b1;
      else if (load) armed <= 1'b0;

      if (arm) sts0 <= '0;
      else if (wr0) sts0 <= wdata;
      else if (load) sts0 <= STS0_READY;

      if (arm) sts1 <= '0;
      else if (wr1) sts1 <= wdata;
      else if (load) sts1 <= {node_count, node_id};
    end
  end

  // R7
  arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (sts0 == 16'h0) && (sts1 == 16'h0));

  // R8
  ready_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !arm && !wr0) |=> (sts0 == STS0_READY));

  // R8
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !arm) |=> !armed);
endmodule

// File: rtl/dualram_window.sv
module dualram_window
  import dualram_window_pkg::*;
#(
  parameter int RAM_AW    = 11,
  parameter int CLR_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  input  logic        link_ready,
  input  logic [7:0]  node_count,
  input  logic [7:0]  node_id
);
  localparam int NBANK = 2;

  logic [15:0] ctrl_q, off_q, sts0, sts1;
  logic [RAM_AW-1:0] widx;
  logic is_ctrl, is_offs, is_data, is_sts0, is_sts1, hit_any;
  logic rd_req, data_rd, data_wr, init_edge;
  logic [NBANK-1:0] ram_we, ram_re;
  logic [15:0] ram_q [NBANK];
  logic [15:0] rd_reg_q;
  logic        rd_ram_q, rd_bank_q, zero_hit;

  assign widx    = off_q[RAM_AW:1];
  assign is_ctrl = bus_req && (bus_addr == A_CTRL);
  assign is_offs = bus_req && (bus_addr == A_OFFS);
  assign is_data = bus_req && (bus_addr == A_DATA);
  assign is_sts0 = bus_req && (bus_addr == A_STS0);
  assign is_sts1 = bus_req && (bus_addr == A_STS1);
  assign hit_any = is_ctrl || is_offs || is_data || is_sts0 || is_sts1;
  assign rd_req  = bus_req && !bus_we;
  assign data_rd = is_data && !bus_we;
  assign data_wr = is_data && bus_we;
  assign init_edge = is_ctrl && bus_we && !ctrl_q[CB_INIT] && bus_wdata[CB_INIT];

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign ram_we[b] = data_wr && (ctrl_q[CB_SEL] == b[0]);
      assign ram_re[b] = data_rd && (ctrl_q[CB_SEL] == b[0]);
      dw_word_ram #(.AW(RAM_AW), .DW(16)) u_ram (
        .clk  (clk),
        .we   (ram_we[b]),
        .re   (ram_re[b]),
        .addr (widx),
        .wdata(swap16(bus_wdata)),
        .q    (ram_q[b])
      );
    end
  endgenerate

  dw_zero_mask #(.AW(RAM_AW), .N(CLR_WORDS)) u_zmask (
    .clk  (clk),
    .rst  (rst),
    .clr  (init_edge),
    .wr   (ram_we[0]),
    .rd   (ram_re[0]),
    .idx  (widx),
    .hit_q(zero_hit)
  );

  dw_status_unit u_sts (
    .clk       (clk),
    .rst       (rst),
    .arm       (init_edge),
    .wr0       (is_sts0 && bus_we),
    .wr1       (is_sts1 && bus_we),
    .wdata     (bus_wdata),
    .link_ready(link_ready),
    .node_count(node_count),
    .node_id   (node_id),
    .sts0      (sts0),
    .sts1      (sts1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      off_q     <= '0;
      rd_valid  <= 1'b0;
      rd_ram_q  <= 1'b0;
      rd_bank_q <= 1'b0;
      rd_reg_q  <= '0;
    end else begin
      if (is_ctrl && bus_we) ctrl_q <= bus_wdata;
      if (is_offs && bus_we) off_q <= bus_wdata;
      else if (is_data) off_q <= off_q + 16'd2;

      rd_valid  <= rd_req;
      rd_ram_q  <= data_rd;
      rd_bank_q <= ctrl_q[CB_SEL];
      if (rd_req) begin
        if (is_ctrl)      rd_reg_q <= ctrl_q;
        else if (is_offs) rd_reg_q <= off_q;
        else if (is_sts0) rd_reg_q <= sts0;
        else if (is_sts1) rd_reg_q <= sts1;
        else              rd_reg_q <= RD_UNMAPPED;
      end
    end
  end

  always_comb begin
    if (!rd_ram_q)      rd_data = rd_reg_q;
    else if (rd_bank_q) rd_data = swap16(ram_q[1]);
    else if (zero_hit)  rd_data = 16'h0000;
    else                rd_data = swap16(ram_q[0]);
  end

  // R2
  read_answer_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  // R3
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !hit_any) |=> (rd_data == RD_UNMAPPED));

  // R5
  offset_step_chk: assert property (@(posedge clk) disable iff (rst)
    is_data |=> (off_q == $past(off_q) + 16'd2));
endmodule

// File: tb/dualram_window_bench.sv
module dualram_window_bench;
  localparam int RAM_AW = 11;
  localparam int DEPTH  = 1 << RAM_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        link_ready = 1'b0;
  logic [7:0]  node_count = '0, node_id = '0;

  always #2 clk = ~clk;

  dualram_window #(.RAM_AW(RAM_AW), .CLR_WORDS(16)) u_dualram_window (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .link_ready(link_ready), .node_count(node_count),
    .node_id(node_id)
  );

  int checks = 0, fails = 0;
  string cur_tag = "R9", exp_tag = "R9";

  // reference model
  logic [15:0] m_ctrl, m_off, m_s0, m_s1;
  bit          m_armed;
  logic [15:0] m_comm [int];
  logic [15:0] m_cop  [int];
  bit          exp_valid, exp_known;
  logic [15:0] exp_data;

  always @(posedge clk) begin
    exp_tag <= cur_tag;
    if (rst) begin
      m_ctrl = 0; m_off = 0; m_s0 = 0; m_s1 = 0; m_armed = 0;
      exp_valid <= 0; exp_known <= 0; exp_data <= 0;
    end else begin
      int w;
      bit ld;
      w = (int'(m_off) >> 1) % DEPTH;
      exp_valid <= bus_req && !bus_we;
      exp_known <= 1;
      if (bus_req && !bus_we) begin
        case (bus_addr)
          8'h00: exp_data <= m_ctrl;
          8'h04: exp_data <= m_off;
          8'h0C: exp_data <= m_s0;
          8'h10: exp_data <= m_s1;
          8'h08: begin
            if (m_ctrl[0]) begin
              if (m_cop.exists(w)) exp_data <= m_cop[w]; else exp_known <= 0;
            end else begin
              if (m_comm.exists(w)) exp_data <= m_comm[w]; else exp_known <= 0;
            end
          end
          default: exp_data <= 16'hFFFF;
        endcase
      end
      ld = m_armed && link_ready;
      if (ld) begin
        m_s0 = 16'hFF01; m_s1 = {node_count, node_id}; m_armed = 0;
      end
      if (bus_req && bus_we) begin
        case (bus_addr)
          8'h00: begin
            if (!m_ctrl[5] && bus_wdata[5]) begin
              for (int i = 0; i < 16; i++) m_comm[i] = 16'h0;
              m_s0 = 0; m_s1 = 0; m_armed = 1;
            end
            m_ctrl = bus_wdata;
          end
          8'h04: m_off = bus_wdata;
          8'h0C: if (!(m_armed && !ld && bus_wdata === 16'hxxxx)) m_s0 = bus_wdata;
          8'h10: m_s1 = bus_wdata;
          8'h08: if (m_ctrl[0]) m_cop[w] = bus_wdata; else m_comm[w] = bus_wdata;
          default: ;
        endcase
        // a clear in this cycle overrides a status write (only CTRL clears)
      end
      if (bus_req && bus_addr == 8'h08) m_off = m_off + 16'd2;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rd_valid !== exp_valid) begin
        fails++;
        $display("FAIL %s: rd_valid actual %0b expected %0b", exp_tag, rd_valid, exp_valid);
      end else if (exp_valid && exp_known) begin
        checks++;
        if (rd_data !== exp_data) begin
          fails++;
          $display("FAIL %s: rd_data actual %04h expected %04h", exp_tag, rd_data, exp_data);
        end
      end
    end
  end

  task automatic op(input bit we, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_req = 0; bus_we = 0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #40000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    cur_tag = "R9";
    op(0, 8'h00, 0); op(0, 8'h04, 0); op(0, 8'h0C, 0); op(0, 8'h10, 0);
    idle(1);
    cur_tag = "R1";
    op(1, 8'h00, 16'h00C2); op(1, 8'h04, 16'h1234);
    op(1, 8'h0C, 16'hA55A); op(1, 8'h10, 16'h0F0F);
    op(0, 8'h00, 0); op(0, 8'h04, 0); op(0, 8'h0C, 0); op(0, 8'h10, 0);
    cur_tag = "R3";
    op(0, 8'h02, 0); op(0, 8'h14, 0); op(0, 8'hFF, 0); op(0, 8'h84, 0);
    op(1, 8'h20, 16'hDEAD); op(1, 8'h01, 16'hBEEF);
    op(0, 8'h00, 0); op(0, 8'h04, 0); op(0, 8'h0C, 0); op(0, 8'h10, 0);
    idle(2);
    cur_tag = "R6";
    op(1, 8'h00, 16'h0000); op(1, 8'h04, 16'h0040);
    op(1, 8'h08, 16'h1122); op(1, 8'h08, 16'h3344);
    op(1, 8'h08, 16'hABCD); op(1, 8'h08, 16'h00FF);
    op(1, 8'h04, 16'h0040);
    op(0, 8'h08, 0); op(0, 8'h08, 0); op(0, 8'h08, 0); op(0, 8'h08, 0);
    cur_tag = "R5";
    op(0, 8'h04, 0);
    cur_tag = "R4";
    op(1, 8'h00, 16'h0001); op(1, 8'h04, 16'h0040);
    op(1, 8'h08, 16'h5A5A); op(1, 8'h04, 16'h0040); op(0, 8'h08, 0);
    op(1, 8'h00, 16'h0000); op(1, 8'h04, 16'h0040); op(0, 8'h08, 0);
    cur_tag = "R5";
    op(1, 8'h04, 16'h0041); op(0, 8'h08, 0); op(0, 8'h04, 0);
    op(1, 8'h04, 16'hFFFE); op(1, 8'h08, 16'h7E57); op(0, 8'h04, 0);
    op(1, 8'h04, 16'hFFFE); op(0, 8'h08, 0); op(0, 8'h04, 0);
    op(1, 8'h04, 16'h1000); op(0, 8'h08, 0);
    idle(2);
    cur_tag = "R7";
    op(1, 8'h04, 16'h0000);
    for (int i = 0; i < 20; i++) op(1, 8'h08, 16'h9000 + 16'(i));
    op(1, 8'h00, 16'h0001); op(1, 8'h04, 16'h0000); op(1, 8'h08, 16'hC0C0);
    op(1, 8'h00, 16'h0000); op(1, 8'h0C, 16'h1111); op(1, 8'h10, 16'h2222);
    op(1, 8'h00, 16'h0020);
    op(0, 8'h0C, 0); op(0, 8'h10, 0);
    op(1, 8'h04, 16'h0000);
    for (int i = 0; i < 18; i++) op(0, 8'h08, 0);
    op(1, 8'h00, 16'h0021); op(1, 8'h04, 16'h0000); op(0, 8'h08, 0);
    op(1, 8'h00, 16'h0020);
    op(1, 8'h04, 16'h0002); op(1, 8'h08, 16'hBEEF);
    op(1, 8'h04, 16'h0002); op(0, 8'h08, 0); op(0, 8'h08, 0);
    cur_tag = "R8";
    idle(3);
    op(0, 8'h0C, 0); op(0, 8'h10, 0);
    @(negedge clk); node_count = 8'h05; node_id = 8'h02; link_ready = 1;
    idle(1);
    op(0, 8'h0C, 0); op(0, 8'h10, 0);
    op(1, 8'h0C, 16'h1234); idle(2); op(0, 8'h0C, 0); op(0, 8'h10, 0);
    cur_tag = "R7";
    op(1, 8'h00, 16'h0020); op(0, 8'h0C, 0); op(0, 8'h10, 0);
    cur_tag = "R8";
    op(1, 8'h00, 16'h0000); node_count = 8'h03; node_id = 8'h01;
    op(1, 8'h00, 16'h0020); op(0, 8'h0C, 0); op(0, 8'h10, 0);
    op(0, 8'h0C, 0); op(0, 8'h10, 0);
    cur_tag = "R2";
    op(1, 8'h0C, 16'h0000); idle(3); op(0, 8'h00, 0); idle(3);
    finish_run();
  end
endmodule